// File: doc/BRIEF.md
# Interrupt Masking and Vectoring Sequencer

This block sits beside the fetch stage of a small processor core and decides when program flow must leave for an interrupt handler and when it must come back. Six level-sensitive request sources arrive each cycle: machine check, critical input, watchdog timer, external input, decrementer and fixed-interval timer. Each source is gated by an enable bit in a machine state word that the block owns. The highest-ranked unmasked source wins. The block saves the resume address and the current state word into one of two save pairs, edits the state word for handler entry, and emits a one-cycle redirect with the handler address.

Critical sources use their own save pair and their own return strobe. They are masked by a separate enable bit, so a critical source can interrupt a running noncritical handler without losing that handler's saved context. A return strobe copies the matching pair back, so the state word and the fetch address are exactly as they were saved. Handler addresses are a selectable base plus a per-source offset that steps by 0x100.

The sequencer has five states. RUN samples strobes and requests. TAKE_NC and TAKE_CR are the noncritical and critical entry cycles. RET_NC and RET_CR are the two return cycles. The only transitions are RUN to one of the four others, and from each of those back to RUN one cycle later. RUN also loops to itself when nothing is pending.

Top module: `intr_vector_seq`

## Requirements
- R1: After reset the state word, both save pairs and the redirect address are zero, `redirect_vld` is low, and no request of any kind causes a redirect until software sets an enable bit.
- R2: State word bit 0 (external enable) gates external, decrementer and fixed-interval sources. Bit 1 (critical enable) gates the critical input and watchdog sources. Bit 2 (machine-check enable) gates machine check. A source whose enable bit is clear never causes a redirect.
- R3: The watchdog, decrementer and fixed-interval sources are each pending only when both their status input and their enable input are high, in addition to the state word gate of R2.
- R4: When several unmasked sources are pending together, the winner is chosen in this order: machine check, critical input, watchdog, external, decrementer, fixed-interval.
- R5: Each source has an index n: critical input 0, machine check 1, external 4, decrementer 9, fixed-interval 10, watchdog 11. The handler address is base + 0x100·(n+1). The base is 0x0000_0000 when `vec_base_sel` is 0 and 0xE000_0000 when it is 1.
- R6: Taking a noncritical source (external, decrementer, fixed-interval) stores `pc_next` and the old state word into the noncritical pair. It then clears bit 0 and bit 3 (user mode) of the state word and keeps all other bits.
- R7: Taking a critical source (machine check, critical input, watchdog) stores `pc_next` and the old state word into the critical pair. It clears bits 0, 1 and 3, and machine check also clears bit 2. All other bits are kept.
- R8: A critical source may be taken while a noncritical handler runs (bit 0 clear, bit 1 set). The noncritical pair is left untouched.
- R9: `rfi_strobe` loads the state word from the noncritical pair and redirects to its saved address. `rfci_strobe` does the same from the critical pair. The pairs themselves are unchanged by a return.
- R10: Strobes and requests are sampled at a rising edge while in RUN. `redirect_vld` is high for exactly the following cycle, with `redirect_addr`, the state word and the save pairs already updated in that cycle.
- R11: In RUN a return strobe takes precedence over any pending request in the same cycle, and `rfci_strobe` takes precedence over `rfi_strobe`. Strobes and requests present during a redirect cycle are not acted on.
- R12: `msr_wr_en` in RUN loads `msr_wr_data` into the state word at that edge, unless a return or an entry happens at the same edge; in that case the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mchk_req | input | 1 | Machine check request level |
| crit_req | input | 1 | Critical input request level |
| wdog_sts | input | 1 | Watchdog status flag |
| wdog_ie | input | 1 | Watchdog interrupt enable |
| ext_req | input | 1 | External input request level |
| dec_sts | input | 1 | Decrementer status flag |
| dec_ie | input | 1 | Decrementer interrupt enable |
| fit_sts | input | 1 | Fixed-interval timer status flag |
| fit_ie | input | 1 | Fixed-interval timer interrupt enable |
| pc_next | input | ADDR_W | Address at which the interrupted flow resumes |
| vec_base_sel | input | 1 | Handler table base: 0 low memory, 1 high base |
| rfi_strobe | input | 1 | Return from noncritical handler |
| rfci_strobe | input | 1 | Return from critical handler |
| msr_wr_en | input | 1 | State word write enable |
| msr_wr_data | input | MSR_W | State word write value |
| redirect_vld | output | 1 | One-cycle fetch redirect pulse |
| redirect_addr | output | ADDR_W | Redirect target address |
| state_word | output | MSR_W | Current machine state word |
| nc_save_pc | output | ADDR_W | Noncritical saved address |
| nc_save_state | output | MSR_W | Noncritical saved state word |
| cr_save_pc | output | ADDR_W | Critical saved address |
| cr_save_state | output | MSR_W | Critical saved state word |

## Verification
The bench raises all six sources at once and then drops the current winner one at a time. Each step separates one rank of the priority chain, and each vector address shows which source won. Masked runs clear one enable bit at a time and hold the gated sources high for several cycles, which separates a wrong gate bit from a wrong source. The timer sources are driven with only status or only enable high, which shows that both inputs are needed. Entries of both classes are interleaved with returns and a nested critical entry; the two save pairs are compared afterwards, which catches a write to the wrong pair. Same-cycle collisions of a strobe with a request, of the two strobes, and of a state write with an entry check the ordering at a single edge.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

    // state word field positions
    localparam int EE_BIT = 0;
    localparam int CE_BIT = 1;
    localparam int ME_BIT = 2;
    localparam int PR_BIT = 3;

    // sources are numbered in priority order, slot 0 ranks highest
    localparam int NUM_SRC = 6;
    localparam int SRC_W   = $clog2(NUM_SRC);

    typedef enum logic [2:0] {
        ST_RUN,
        ST_TAKE_NC,
        ST_TAKE_CR,
        ST_RET_NC,
        ST_RET_CR
    } seq_state_t;

    // handler table index per slot
    function automatic int src_vec_idx(input int s);
        case (s)
            0:       return 1;   // machine check
            1:       return 0;   // critical input
            2:       return 11;  // watchdog
            3:       return 4;   // external
            4:       return 9;   // decrementer
            default: return 10;  // fixed interval
        endcase
    endfunction

    // state word bit that gates each slot
    function automatic int src_gate_bit(input int s);
        case (s)
            0:       return ME_BIT;
            1, 2:    return CE_BIT;
            default: return EE_BIT;
        endcase
    endfunction

    function automatic bit src_is_crit(input int s);
        return (s < 3);
    endfunction

    function automatic bit src_clears_me(input int s);
        return (s == 0);
    endfunction

endpackage

// File: rtl/ivs_select.sv
module ivs_select #(
    parameter int NSRC  = 6,
    parameter int MSR_W = 32,
    localparam int SW   = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  raw,
    input  logic [MSR_W-1:0] msr,
    output logic             win_vld,
    output logic [SW-1:0]    win_src
);

    logic [NSRC-1:0] gated;

    generate
        for (genvar i = 0; i < NSRC; i++) begin : g_gate
            localparam int GB = ivs_pkg::src_gate_bit(i);
            assign gated[i] = raw[i] & msr[GB];
        end
    endgenerate

    // lowest slot number wins
    always_comb begin
        win_vld = 1'b0;
        win_src = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (gated[i]) begin
                win_vld = 1'b1;
                win_src = SW'(i);
            end
        end
    end

endmodule

// File: rtl/ivs_save_pair.sv
module ivs_save_pair #(
    parameter int AW = 32,
    parameter int SW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_en,
    input  logic [AW-1:0] pc_in,
    input  logic [SW-1:0] st_in,
    output logic [AW-1:0] pc_q,
    output logic [SW-1:0] st_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            st_q <= '0;
        end else if (cap_en) begin
            pc_q <= pc_in;
            st_q <= st_in;
        end
    end

    AST_PAIR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> ($stable(pc_q) && $stable(st_q))); // R9

endmodule

// File: rtl/intr_vector_seq.sv
module intr_vector_seq #(
    parameter int                ADDR_W     = 32,
    parameter int                MSR_W      = 32,
    parameter int unsigned       VEC_STEP   = 256,
    parameter logic [ADDR_W-1:0] FLASH_BASE = 'hE000_0000,
    parameter logic [MSR_W-1:0]  MSR_RESET  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mchk_req,
    input  logic              crit_req,
    input  logic              wdog_sts,
    input  logic              wdog_ie,
    input  logic              ext_req,
    input  logic              dec_sts,
    input  logic              dec_ie,
    input  logic              fit_sts,
    input  logic              fit_ie,
    input  logic [ADDR_W-1:0] pc_next,
    input  logic              vec_base_sel,
    input  logic              rfi_strobe,
    input  logic              rfci_strobe,
    input  logic              msr_wr_en,
    input  logic [MSR_W-1:0]  msr_wr_data,
    output logic              redirect_vld,
    output logic [ADDR_W-1:0] redirect_addr,
    output logic [MSR_W-1:0]  state_word,
    output logic [ADDR_W-1:0] nc_save_pc,
    output logic [MSR_W-1:0]  nc_save_state,
    output logic [ADDR_W-1:0] cr_save_pc,
    output logic [MSR_W-1:0]  cr_save_state
);
    import ivs_pkg::*;

    localparam int NPAIR   = 2;
    localparam int PAIR_NC = 0;
    localparam int PAIR_CR = 1;

    seq_state_t        state_q, state_d;
    logic [MSR_W-1:0]  msr_q, msr_d;
    logic [ADDR_W-1:0] tgt_q, tgt_d;
    logic [NUM_SRC-1:0] raw_req;
    logic              win_vld;
    logic [SRC_W-1:0]  win_src;
    logic              win_crit;
    logic [ADDR_W-1:0] vec_base, vec_addr;
    logic [MSR_W-1:0]  entry_msr;
    logic [NPAIR-1:0]  cap;
    logic [ADDR_W-1:0] pair_pc [NPAIR];
    logic [MSR_W-1:0]  pair_st [NPAIR];

    // request levels in priority slot order
    assign raw_req = {fit_sts & fit_ie, dec_sts & dec_ie, ext_req,
                      wdog_sts & wdog_ie, crit_req, mchk_req};

    ivs_select #(.NSRC(NUM_SRC), .MSR_W(MSR_W)) u_select (
        .raw     (raw_req),
        .msr     (msr_q),
        .win_vld (win_vld),
        .win_src (win_src)
    );

    generate
        for (genvar g = 0; g < NPAIR; g++) begin : g_pair
            ivs_save_pair #(.AW(ADDR_W), .SW(MSR_W)) u_pair (
                .clk    (clk),
                .rst_n  (rst_n),
                .cap_en (cap[g]),
                .pc_in  (pc_next),
                .st_in  (msr_q),
                .pc_q   (pair_pc[g]),
                .st_q   (pair_st[g])
            );
        end
    endgenerate

    // handler address and entry state word for the current winner
    always_comb begin
        win_crit  = src_is_crit(int'(win_src));
        vec_base  = vec_base_sel ? FLASH_BASE : '0;
        vec_addr  = vec_base + ADDR_W'(VEC_STEP) * ADDR_W'(src_vec_idx(int'(win_src)) + 1);
        entry_msr = msr_q;
        entry_msr[EE_BIT] = 1'b0;
        entry_msr[PR_BIT] = 1'b0;
        if (win_crit) begin
            entry_msr[CE_BIT] = 1'b0;
        end
        if (src_clears_me(int'(win_src))) begin
            entry_msr[ME_BIT] = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state: returns first, then entries
    always_comb begin
        state_d = ST_RUN;
        unique case (state_q)
            ST_RUN: begin
                if (rfci_strobe) begin
                    state_d = ST_RET_CR;
                end else if (rfi_strobe) begin
                    state_d = ST_RET_NC;
                end else if (win_vld) begin
                    state_d = win_crit ? ST_TAKE_CR : ST_TAKE_NC;
                end else begin
                    state_d = ST_RUN;
                end
            end
            ST_TAKE_NC: state_d = ST_RUN;
            ST_TAKE_CR: state_d = ST_RUN;
            ST_RET_NC:  state_d = ST_RUN;
            ST_RET_CR:  state_d = ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    // datapath updates decided in RUN
    always_comb begin
        msr_d = msr_q;
        tgt_d = tgt_q;
        cap   = '0;
        if (state_q == ST_RUN) begin
            unique case (state_d)
                ST_RET_CR: begin
                    msr_d = pair_st[PAIR_CR];
                    tgt_d = pair_pc[PAIR_CR];
                end
                ST_RET_NC: begin
                    msr_d = pair_st[PAIR_NC];
                    tgt_d = pair_pc[PAIR_NC];
                end
                ST_TAKE_CR: begin
                    cap[PAIR_CR] = 1'b1;
                    msr_d = entry_msr;
                    tgt_d = vec_addr;
                end
                ST_TAKE_NC: begin
                    cap[PAIR_NC] = 1'b1;
                    msr_d = entry_msr;
                    tgt_d = vec_addr;
                end
                default: begin
                    if (msr_wr_en) begin
                        msr_d = msr_wr_data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            msr_q <= MSR_RESET;
            tgt_q <= '0;
        end else begin
            msr_q <= msr_d;
            tgt_q <= tgt_d;
        end
    end

    // outputs
    always_comb begin
        redirect_vld  = (state_q != ST_RUN);
        redirect_addr = tgt_q;
        state_word    = msr_q;
        nc_save_pc    = pair_pc[PAIR_NC];
        nc_save_state = pair_st[PAIR_NC];
        cr_save_pc    = pair_pc[PAIR_CR];
        cr_save_state = pair_st[PAIR_CR];
    end

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_vld |=> !redirect_vld); // R10

    AST_MASKED_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect_vld && !state_word[EE_BIT] && !state_word[CE_BIT] && !state_word[ME_BIT]
         && !rfi_strobe && !rfci_strobe) |=> !redirect_vld); // R2

    AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE_NC || state_q == ST_TAKE_CR) |-> (redirect_addr[7:0] == 8'h00)); // R5

    AST_ENTRY_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE_NC || state_q == ST_TAKE_CR)
        |-> (!state_word[EE_BIT] && !state_word[PR_BIT])); // R6

    AST_CRIT_CLEARS_CE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE_CR) |-> !state_word[CE_BIT]); // R7

    AST_NC_PAIR_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAKE_CR) |-> ($stable(nc_save_pc) && $stable(nc_save_state))); // R8

    AST_RET_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RET_NC) |-> (state_word == nc_save_state && redirect_addr == nc_save_pc)); // R9

endmodule

// File: tb/sim_intr_vector_seq.sv
module sim_intr_vector_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mchk_req = 0, crit_req = 0, wdog_sts = 0, wdog_ie = 0, ext_req = 0;
    logic        dec_sts = 0, dec_ie = 0, fit_sts = 0, fit_ie = 0;
    logic [31:0] pc_next = '0;
    logic        vec_base_sel = 0, rfi_strobe = 0, rfci_strobe = 0, msr_wr_en = 0;
    logic [31:0] msr_wr_data = '0;
    logic        redirect_vld;
    logic [31:0] redirect_addr, state_word, nc_save_pc, nc_save_state, cr_save_pc, cr_save_state;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    bit prev_vld = 0;
    logic [31:0] q_addr[$];
    logic [31:0] q_msr[$];
    string       q_tag[$];

    always #10 clk = ~clk;  // 50 MHz

    intr_vector_seq u0 (
        .clk(clk), .rst_n(rst_n), .mchk_req(mchk_req), .crit_req(crit_req),
        .wdog_sts(wdog_sts), .wdog_ie(wdog_ie), .ext_req(ext_req),
        .dec_sts(dec_sts), .dec_ie(dec_ie), .fit_sts(fit_sts), .fit_ie(fit_ie),
        .pc_next(pc_next), .vec_base_sel(vec_base_sel),
        .rfi_strobe(rfi_strobe), .rfci_strobe(rfci_strobe),
        .msr_wr_en(msr_wr_en), .msr_wr_data(msr_wr_data),
        .redirect_vld(redirect_vld), .redirect_addr(redirect_addr),
        .state_word(state_word), .nc_save_pc(nc_save_pc), .nc_save_state(nc_save_state),
        .cr_save_pc(cr_save_pc), .cr_save_state(cr_save_state)
    );

    function automatic logic [31:0] vaddr(input int n, input bit sel);
        return (sel ? 32'hE000_0000 : 32'h0) + 32'h100 * (n + 1);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // bit0 mchk, bit1 crit, bit2 watchdog, bit3 external, bit4 decrementer, bit5 fixed interval
    task automatic set_req(input logic [5:0] r);
        mchk_req = r[0];
        crit_req = r[1];
        wdog_sts = r[2]; wdog_ie = r[2];
        ext_req  = r[3];
        dec_sts  = r[4]; dec_ie  = r[4];
        fit_sts  = r[5]; fit_ie  = r[5];
    endtask

    task automatic write_msr(input logic [31:0] v);
        msr_wr_en = 1; msr_wr_data = v;
        @(negedge clk);
        msr_wr_en = 0;
        @(negedge clk);
    endtask

    // driver: one sampled cycle of stimulus, expected redirect pushed to scoreboard
    task automatic fire(input logic [5:0] r, input logic [31:0] pc, input bit sel,
                        input bit rfi, input bit rfci, input bit wen, input logic [31:0] wdat,
                        input logic [31:0] eaddr, input logic [31:0] emsr, input string tag);
        set_req(r);
        pc_next = pc; vec_base_sel = sel;
        rfi_strobe = rfi; rfci_strobe = rfci;
        msr_wr_en = wen; msr_wr_data = wdat;
        q_addr.push_back(eaddr); q_msr.push_back(emsr); q_tag.push_back(tag);
        @(negedge clk);
        set_req(6'b0);
        rfi_strobe = 0; rfci_strobe = 0; msr_wr_en = 0;
        @(negedge clk);
    endtask

    task automatic hold_quiet(input logic [5:0] r, input int ncyc, input logic [31:0] exp_msr,
                              input string tag);
        set_req(r);
        repeat (ncyc) @(negedge clk);
        set_req(6'b0);
        repeat (2) @(negedge clk);
        chk(tag, state_word, exp_msr);
    endtask

    task automatic timer_quiet(input logic [5:0] sts_ie, input logic [31:0] exp_msr);
        {fit_ie, fit_sts, dec_ie, dec_sts, wdog_ie, wdog_sts} = sts_ie;
        repeat (3) @(negedge clk);
        {fit_ie, fit_sts, dec_ie, dec_sts, wdog_ie, wdog_sts} = '0;
        repeat (2) @(negedge clk);
        chk("R3 half-enabled timer", state_word, exp_msr);
    endtask

    // monitor: pops expected redirects, also checks pulse width
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (prev_vld) begin
                nchk++;
                if (redirect_vld) begin
                    nfail++;
                    $display("FAIL R10 pulse width actual=1 expected=0");
                end
            end
            if (redirect_vld) begin
                nchk++;
                if (q_addr.size() == 0) begin
                    nfail++;
                    $display("FAIL R2 unexpected redirect actual=%h expected=none", redirect_addr);
                end else begin
                    automatic logic [31:0] ea = q_addr.pop_front();
                    automatic logic [31:0] em = q_msr.pop_front();
                    automatic string       tg = q_tag.pop_front();
                    if (redirect_addr !== ea || state_word !== em) begin
                        nfail++;
                        $display("FAIL %s actual=%h/%h expected=%h/%h", tg,
                                 redirect_addr, state_word, ea, em);
                    end
                end
            end
            prev_vld <= redirect_vld;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 state word", state_word, 32'h0);
        chk("R1 nc pc", nc_save_pc, 32'h0);
        chk("R1 nc state", nc_save_state, 32'h0);
        chk("R1 cr pc", cr_save_pc, 32'h0);
        chk("R1 cr state", cr_save_state, 32'h0);
        chk("R1 redirect", {31'h0, redirect_vld}, 32'h0);
        hold_quiet(6'b111111, 3, 32'h0, "R1 all masked after reset");

        // R12 write, R6 noncritical entry
        write_msr(32'hA5A5_0009);
        chk("R12 state write", state_word, 32'hA5A5_0009);
        fire(6'b001000, 32'h1000, 0, 0, 0, 0, 0, vaddr(4, 0), 32'hA5A5_0000, "R6 external entry");
        chk("R6 nc pc", nc_save_pc, 32'h1000);
        chk("R6 nc state", nc_save_state, 32'hA5A5_0009);

        // R7/R8 critical entry inside noncritical handler, high base
        write_msr(32'hA5A5_0002);
        fire(6'b000010, 32'h2000, 1, 0, 0, 0, 0, vaddr(0, 1), 32'hA5A5_0000, "R7 critical entry");
        chk("R7 cr pc", cr_save_pc, 32'h2000);
        chk("R7 cr state", cr_save_state, 32'hA5A5_0002);
        chk("R8 nc pc kept", nc_save_pc, 32'h1000);
        chk("R8 nc state kept", nc_save_state, 32'hA5A5_0009);

        // R9 returns
        fire(6'b0, 32'h0, 0, 0, 1, 0, 0, 32'h2000, 32'hA5A5_0002, "R9 critical return");
        fire(6'b0, 32'h0, 0, 1, 0, 0, 0, 32'h1000, 32'hA5A5_0009, "R9 normal return");
        chk("R9 cr state unchanged", cr_save_state, 32'hA5A5_0002);

        // R4/R5 priority ladder
        write_msr(32'hF);
        fire(6'b111111, 32'h4000, 0, 0, 0, 0, 0, vaddr(1, 0), 32'h0, "R4 machine check first");
        fire(6'b0, 32'h0, 0, 0, 1, 0, 0, 32'h4000, 32'hF, "R9 return after mchk");
        fire(6'b111110, 32'h4100, 0, 0, 0, 0, 0, vaddr(0, 0), 32'h4, "R4 critical second");
        fire(6'b0, 32'h0, 0, 0, 1, 0, 0, 32'h4100, 32'hF, "R9 return after crit");
        fire(6'b111100, 32'h4200, 0, 0, 0, 0, 0, vaddr(11, 0), 32'h4, "R4 watchdog third");
        fire(6'b0, 32'h0, 0, 0, 1, 0, 0, 32'h4200, 32'hF, "R9 return after wdog");
        fire(6'b111000, 32'h4300, 0, 0, 0, 0, 0, vaddr(4, 0), 32'h6, "R4 external fourth");
        fire(6'b0, 32'h0, 0, 1, 0, 0, 0, 32'h4300, 32'hF, "R9 return after ext");
        fire(6'b110000, 32'h4400, 0, 0, 0, 0, 0, vaddr(9, 0), 32'h6, "R4 decrementer fifth");
        fire(6'b0, 32'h0, 0, 1, 0, 0, 0, 32'h4400, 32'hF, "R9 return after dec");
        fire(6'b100000, 32'h4500, 1, 0, 0, 0, 0, vaddr(10, 1), 32'h6, "R5 fixed interval high base");
        fire(6'b0, 32'h0, 0, 1, 0, 0, 0, 32'h4500, 32'hF, "R9 return after fit");

        // R3 status without enable and enable without status
        timer_quiet(6'b000001, 32'hF);
        timer_quiet(6'b000010, 32'hF);
        timer_quiet(6'b000100, 32'hF);
        timer_quiet(6'b001000, 32'hF);
        timer_quiet(6'b010000, 32'hF);
        timer_quiet(6'b100000, 32'hF);

        // R2 single enable bit cleared
        write_msr(32'hE);
        hold_quiet(6'b111000, 3, 32'hE, "R2 external enable off");
        write_msr(32'hD);
        hold_quiet(6'b000110, 3, 32'hD, "R2 critical enable off");
        write_msr(32'hB);
        hold_quiet(6'b000001, 3, 32'hB, "R2 machine check enable off");

        // R11 strobe beats request, rfci beats rfi
        write_msr(32'h1);
        fire(6'b001000, 32'h5000, 0, 0, 0, 0, 0, vaddr(4, 0), 32'h0, "R6 external entry");
        write_msr(32'h3);
        fire(6'b001010, 32'h0, 0, 1, 0, 0, 0, 32'h5000, 32'h1, "R11 return beats request");
        fire(6'b0, 32'h0, 0, 1, 1, 0, 0, 32'h4200, 32'hF, "R11 rfci beats rfi");

        // R12 write dropped on entry
        fire(6'b001000, 32'h6000, 0, 0, 0, 1, 32'hFF, vaddr(4, 0), 32'h6, "R12 write dropped");
        chk("R12 saved pre-write word", nc_save_state, 32'hF);

        // R8 nested critical entry
        fire(6'b000010, 32'h6100, 0, 0, 0, 0, 0, vaddr(0, 0), 32'h4, "R8 nested critical");
        chk("R8 nc pc kept", nc_save_pc, 32'h6000);
        fire(6'b0, 32'h0, 0, 0, 1, 0, 0, 32'h6100, 32'h6, "R9 back to nc handler");
        fire(6'b0, 32'h0, 0, 1, 0, 0, 0, 32'h6000, 32'hF, "R9 back to program");

        repeat (2) @(negedge clk);
        chk("R10 all expected redirects seen", q_addr.size(), 32'h0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule